// File: doc/BRIEF.md
# Multi-Scheme Transmit Modulation Controller

This block sits between a serial transmit data bit and the two actuators of a narrowband transmitter: the fractional word of a fractional-N synthesizer and the level code of a power-amplifier DAC. A 2-bit scheme field chooses between two frequency-keyed modes and two amplitude-keyed modes. The chosen mode decides whether the data bit moves the synthesizer fraction or switches the PA code.

In the frequency modes, the fraction moves up or down from a programmed centre word. In plain frequency keying the step is a 7-bit deviation count. In the Gaussian variant the step is a power of two. In the amplitude modes, the fraction stays at the centre word and the data bit picks between two PA codes, or between one code and off.

For the Gaussian mode the block also generates a data-rate clock on the reference-clock grid. The data bit is captured on each rising edge of that clock, so that an external shifter can feed bits in step. An optional control inverts the data bit before it is used. All outputs are registered.

Top module: `tx_mod_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `frac_word`, `pa_level`, `pa_en` and `txclk` are all zero.
- R2: Scheme codes are 00 = frequency keying (FK), 01 = Gaussian frequency keying (GFK), 10 = amplitude keying (AK) and 11 = on-off keying (OOK). In FK, one cycle after the inputs, `frac_word` equals `base_frac + dev_code` for an effective bit of 1. For an effective bit of 0 it equals `base_frac - dev_code`. Both results wrap modulo 2^12.
- R3: In FK with `dev_code` = 0, `frac_word` equals `base_frac` whatever the data bit.
- R4: In GFK the offset is 2^`gmc` (gmc 0..7), added for an effective bit of 1 and subtracted for 0, modulo 2^12.
- R5: In GFK, `txclk` is a square wave with period max(`div_fac`,1) × {16,32,64,128}[`idx_sel`] cycles and 50 % duty. It starts low when GFK is entered. Outside GFK it is held low.
- R6: In GFK, the effective bit is captured at the clock edge where `txclk` rises. It is held until the next rise, and `frac_word` reflects it one cycle later.
- R7: In AK, `frac_word` equals `base_frac`. `pa_level` is `pwr_code` for an effective bit of 1 and `dev_code` for 0.
- R8: In OOK, `frac_word` equals `base_frac`. `pa_level` is `pwr_code` for an effective bit of 1, and 0 with `pa_en` low for 0.
- R9: `pa_en` is high exactly when bits [6:5] (the range field) of the driven `pa_level` are not 00.
- R10: With `data_inv` high, the effective bit is the complement of `tx_bit` in every mode.
- R11: In FK and GFK, `pa_level` equals `pwr_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference (comparison) clock |
| rst | input | 1 | Synchronous active-high reset |
| scheme | input | 2 | Modulation scheme code |
| dev_code | input | 7 | FK deviation count / AK low-level code |
| pwr_code | input | 7 | PA code for a 1 bit (range in [6:5]) |
| gmc | input | 3 | GFK deviation exponent |
| idx_sel | input | 2 | GFK index multiplier select |
| div_fac | input | 7 | GFK divider factor |
| base_frac | input | 12 | Centre fractional word |
| data_inv | input | 1 | Invert the transmit bit |
| tx_bit | input | 1 | Transmit data bit |
| frac_word | output | 12 | Active fractional-N word |
| pa_level | output | 7 | PA DAC code |
| pa_en | output | 1 | PA stage enable |
| txclk | output | 1 | GFK data-rate clock |

## Verification
The assertions assume the following about the inputs:
- All inputs change only between clock edges.
- `div_fac` and `idx_sel` are steady while a GFK run is counting.
- The GFK hold property compares consecutive cycles only when `base_frac` and `gmc` have not moved.

The stimulus meets these assumptions:
- It drives every input on the falling edge.
- It sets each configuration once per segment.
- It changes only `tx_bit` from cycle to cycle inside a segment.

// File: rtl/tx_mod_pkg.sv
package tx_mod_pkg;

    typedef enum logic [1:0] {
        SCH_FK   = 2'b00,
        SCH_GFK  = 2'b01,
        SCH_AK   = 2'b10,
        SCH_OOK  = 2'b11
    } scheme_e;

    typedef struct packed {
        logic steer_freq;
        logic gauss;
        logic steer_amp;
        logic off_on_zero;
    } mode_dec_t;

    function automatic mode_dec_t decode_scheme(input logic [1:0] code);
        mode_dec_t d;
        d = '0;
        case (scheme_e'(code))
            SCH_FK:  d.steer_freq = 1'b1;
            SCH_GFK: begin d.steer_freq = 1'b1; d.gauss = 1'b1; end
            SCH_AK:  d.steer_amp = 1'b1;
            default: begin d.steer_amp = 1'b1; d.off_on_zero = 1'b1; end
        endcase
        return d;
    endfunction

    function automatic logic range_live(input logic [1:0] rng);
        return rng != 2'b00;
    endfunction

endpackage

// File: rtl/tx_rate_gen.sv
module tx_rate_gen #(
    parameter int unsigned DIV_W = 7,
    parameter int unsigned IDX_W = 2,
    parameter int unsigned IDX_BASE_LOG = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             txclk_o,
    output logic             tick_o
);
    localparam int unsigned IDX_MAX_LOG = IDX_BASE_LOG + (1 << IDX_W) - 1;
    localparam int unsigned CNT_W = DIV_W + IDX_MAX_LOG + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_eff;
    logic [CNT_W-1:0] idx_val;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;
    logic             wrap;
    logic             clk_q;

    always_comb begin
        div_eff = (div_i == '0) ? CNT_W'(1) : CNT_W'(div_i);
        idx_val = CNT_W'(1) << (IDX_BASE_LOG + int'(idx_i));
        period  = div_eff * idx_val;
        half    = period >> 1;
        wrap    = (cnt_q >= half - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign txclk_o = clk_q;
    assign tick_o  = en_i && wrap && !clk_q;

    // R5
    txclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !txclk_o);

    // R5
    txclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !wrap) |=> $stable(txclk_o));

endmodule

// File: rtl/tx_bit_hold.sv
module tx_bit_hold (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic bit_i,
    output logic held_o
);
    always_ff @(posedge clk) begin
        if (rst)
            held_o <= 1'b0;
        else if (tick_i)
            held_o <= bit_i;
    end
endmodule

// File: rtl/tx_word_map.sv
module tx_word_map
    import tx_mod_pkg::*;
#(
    parameter int unsigned FRAC_W = 12,
    parameter int unsigned LVL_W  = 7,
    parameter int unsigned MC_W   = 3
) (
    input  mode_dec_t         md_i,
    input  logic              bit_i,
    input  logic [FRAC_W-1:0] base_i,
    input  logic [LVL_W-1:0]  dev_i,
    input  logic [LVL_W-1:0]  pwr_i,
    input  logic [MC_W-1:0]   gmc_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              en_o
);
    logic [FRAC_W-1:0] step;

    always_comb begin
        step = md_i.gauss ? (FRAC_W'(1) << gmc_i) : FRAC_W'(dev_i);

        if (md_i.steer_freq)
            frac_o = bit_i ? (base_i + step) : (base_i - step);
        else
            frac_o = base_i;

        if (md_i.steer_amp) begin
            if (bit_i)
                level_o = pwr_i;
            else if (md_i.off_on_zero)
                level_o = '0;
            else
                level_o = dev_i;
        end else begin
            level_o = pwr_i;
        end

        en_o = range_live(level_o[LVL_W-1 -: 2]);
    end
endmodule

// File: rtl/tx_mod_ctrl.sv
module tx_mod_ctrl
    import tx_mod_pkg::*;
#(
    parameter int unsigned FRAC_W = 12,
    parameter int unsigned LVL_W  = 7,
    parameter int unsigned MC_W   = 3,
    parameter int unsigned DIV_W  = 7,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        scheme,
    input  logic [LVL_W-1:0]  dev_code,
    input  logic [LVL_W-1:0]  pwr_code,
    input  logic [MC_W-1:0]   gmc,
    input  logic [IDX_W-1:0]  idx_sel,
    input  logic [DIV_W-1:0]  div_fac,
    input  logic [FRAC_W-1:0] base_frac,
    input  logic              data_inv,
    input  logic              tx_bit,
    output logic [FRAC_W-1:0] frac_word,
    output logic [LVL_W-1:0]  pa_level,
    output logic              pa_en,
    output logic              txclk
);
    mode_dec_t         md;
    logic              live_bit;
    logic              held_bit;
    logic              eff_bit;
    logic              tick;
    logic [FRAC_W-1:0] frac_n;
    logic [LVL_W-1:0]  level_n;
    logic              en_n;

    assign md       = decode_scheme(scheme);
    assign live_bit = tx_bit ^ data_inv;
    assign eff_bit  = md.gauss ? held_bit : live_bit;

    tx_rate_gen #(.DIV_W(DIV_W), .IDX_W(IDX_W), .IDX_BASE_LOG(4)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .en_i    (md.gauss),
        .div_i   (div_fac),
        .idx_i   (idx_sel),
        .txclk_o (txclk),
        .tick_o  (tick)
    );

    tx_bit_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .bit_i  (live_bit),
        .held_o (held_bit)
    );

    tx_word_map #(.FRAC_W(FRAC_W), .LVL_W(LVL_W), .MC_W(MC_W)) u_map (
        .md_i    (md),
        .bit_i   (eff_bit),
        .base_i  (base_frac),
        .dev_i   (dev_code),
        .pwr_i   (pwr_code),
        .gmc_i   (gmc),
        .frac_o  (frac_n),
        .level_o (level_n),
        .en_o    (en_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frac_word <= '0;
            pa_level  <= '0;
            pa_en     <= 1'b0;
        end else begin
            frac_word <= frac_n;
            pa_level  <= level_n;
            pa_en     <= en_n;
        end
    end

    // R3
    zero_dev_flat_chk: assert property (@(posedge clk) disable iff (rst)
        (scheme == 2'b00 && dev_code == '0) |=> frac_word == $past(base_frac));

    // R7
    amp_mode_centre_chk: assert property (@(posedge clk) disable iff (rst)
        scheme[1] |=> frac_word == $past(base_frac));

    // R8
    ook_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (scheme == 2'b11 && !(tx_bit ^ data_inv)) |=> (pa_level == '0 && !pa_en));

    // R6
    gfk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scheme == 2'b01 && $past(scheme) == 2'b01 && !$past(rst)
         && $stable(base_frac) && $stable(gmc) && !$rose(txclk))
        |=> $stable(frac_word));

endmodule

// File: tb/tx_mod_ctrl_tb.sv
module tx_mod_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  scheme = 2'b00;
    logic [6:0]  dev_code = '0;
    logic [6:0]  pwr_code = '0;
    logic [2:0]  gmc = '0;
    logic [1:0]  idx_sel = '0;
    logic [6:0]  div_fac = '0;
    logic [11:0] base_frac = '0;
    logic        data_inv = 1'b0;
    logic        tx_bit = 1'b0;
    logic [11:0] frac_word;
    logic [6:0]  pa_level;
    logic        pa_en;
    logic        txclk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_frac = 0, m_lvl = 0, m_ph = 0;
    bit m_en = 0, m_clk = 0, m_held = 0;

    always #2 clk = ~clk;

    tx_mod_ctrl u_dut (
        .clk(clk), .rst(rst), .scheme(scheme), .dev_code(dev_code),
        .pwr_code(pwr_code), .gmc(gmc), .idx_sel(idx_sel), .div_fac(div_fac),
        .base_frac(base_frac), .data_inv(data_inv), .tx_bit(tx_bit),
        .frac_word(frac_word), .pa_level(pa_level), .pa_en(pa_en), .txclk(txclk)
    );

    always @(posedge clk) begin
        bit b;
        int off, half, dv;
        if (rst) begin
            m_frac = 0; m_lvl = 0; m_en = 0; m_clk = 0; m_held = 0; m_ph = 0;
        end else begin
            b = (scheme == 2'b01) ? m_held : (tx_bit ^ data_inv);
            case (scheme)
                2'b00, 2'b01: begin
                    off = (scheme == 2'b00) ? int'(dev_code) : (1 << gmc);
                    m_frac = b ? (int'(base_frac) + off) % 4096
                               : (int'(base_frac) + 4096 - off) % 4096;
                    m_lvl = pwr_code;
                end
                2'b10: begin m_frac = base_frac; m_lvl = b ? int'(pwr_code) : int'(dev_code); end
                default: begin m_frac = base_frac; m_lvl = b ? int'(pwr_code) : 0; end
            endcase
            m_en = (m_lvl / 32) != 0;
            if (scheme != 2'b01) begin
                m_ph = 0; m_clk = 0;
            end else begin
                dv = (div_fac == 0) ? 1 : int'(div_fac);
                half = dv * (16 << idx_sel) / 2;
                if (m_ph >= half - 1) begin
                    m_ph = 0;
                    m_clk = !m_clk;
                    if (m_clk) m_held = tx_bit ^ data_inv;
                end else begin
                    m_ph++;
                end
            end
        end
    end

    task automatic compare();
        n_vec++;
        if (frac_word !== m_frac[11:0] || pa_level !== m_lvl[6:0] ||
            pa_en !== m_en || txclk !== m_clk) begin
            n_bad++;
            $display("FAIL %s: frac=%0d lvl=%0d en=%0b clk=%0b expected frac=%0d lvl=%0d en=%0b clk=%0b",
                     cur_req, frac_word, pa_level, pa_en, txclk, m_frac, m_lvl, m_en, m_clk);
        end
    endtask

    task automatic run(input int n, input string req);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            tx_bit = 1'($urandom);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input int dev, input int pwr,
                       input int base, input bit inv);
        @(negedge clk);
        compare();
        scheme = s; dev_code = 7'(dev); pwr_code = 7'(pwr);
        base_frac = 12'(base); data_inv = inv;
    endtask

    task automatic gcfg(input int g, input int idx, input int dv, input bit inv);
        @(negedge clk);
        compare();
        scheme = 2'b01; gmc = 3'(g); idx_sel = 2'(idx); div_fac = 7'(dv); data_inv = inv;
    endtask

    initial begin
        // R1: reset state
        run(4, "R1");
        @(negedge clk); compare(); rst = 1'b0;
        run(1, "R1");
        // R2 / R11: FK centre offsets, varied power ranges
        cfg(2'b00, 37, 7'h55, 1000, 0);   run(40, "R2");
        cfg(2'b00, 100, 7'h1F, 5, 0);     run(30, "R2");   // wrap low
        cfg(2'b00, 127, 7'h7F, 4090, 0);  run(30, "R11");  // wrap high
        // R3: zero deviation
        cfg(2'b00, 0, 7'h40, 2222, 0);    run(20, "R3");
        // R10: inversion in FK
        cfg(2'b00, 9, 7'h30, 300, 1);     run(30, "R10");
        // R7 / R9: AK with low code in range 00
        cfg(2'b10, 7'h1A, 7'h6B, 77, 0);  run(30, "R7");
        cfg(2'b10, 7'h25, 7'h10, 77, 1);  run(30, "R9");
        // R8: OOK
        cfg(2'b11, 7'h33, 7'h5C, 500, 0); run(30, "R8");
        cfg(2'b11, 7'h33, 7'h1C, 500, 1); run(30, "R8");
        // R4 / R5 / R6: GFK configurations
        base_frac = 2048; pwr_code = 7'h61;
        gcfg(0, 0, 1, 0);   run(120, "R5");
        gcfg(3, 1, 2, 0);   run(300, "R6");
        gcfg(7, 0, 3, 1);   run(200, "R4");
        gcfg(5, 3, 0, 0);   run(400, "R5");   // divider 0 treated as 1
        cfg(2'b00, 4, 7'h20, 10, 0); run(10, "R5");  // leaving GFK drops txclk
        gcfg(2, 2, 1, 0);   run(200, "R6");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule